// File: doc/BRIEF.md
# Increment/Decrement Pulse Oscillator

This block is the controlled oscillator stage of an all-digital phase-locked loop. The loop filter is an up/down counter, and it reports each wrap as a short pulse. A carry pulse means "speed up" and a borrow pulse means "slow down". The oscillator turns those pulses into a square wave whose rate follows them. That square wave then feeds a divide-by-N stage elsewhere in the loop.

With no requests, the output is a divide-by-two of the oscillator tick stream. The tick stream runs at 2N times the loop centre frequency. Each carry inserts one extra half cycle into the output, and each borrow removes one. The resulting output frequency is N times the centre frequency plus half of the net carry-minus-borrow pulse rate.

The block runs from one fabric clock. One oscillator tick spans `PHASES` fabric clocks (default 2, must be even). The tick falls on the last phase of each group and the mid point falls on phase `PHASES/2-1`. A nominal output toggle happens once per tick. An inserted toggle is placed at the mid point, and a deletion suppresses a tick toggle.

Top module: `incdec_osc`

## Requirements
- R1: A synchronous active-high reset drives `osc_out` low, restarts the phase count at phase 0 and discards any pending carry or borrow request, so a request taken before reset never appears afterwards.
- R2: With no requests, `osc_out` toggles exactly once per `PHASES` clocks. The toggle happens on the clock edge that ends phase `PHASES-1`, so the first toggle after reset release is on the `PHASES`-th edge and the output period is 2·`PHASES` clocks.
- R3: A carry request produces one extra toggle of `osc_out` on the edge that ends mid phase `PHASES/2-1`. With the default of 2 phases, the output therefore toggles on two consecutive clocks.
- R4: A borrow request suppresses the next tick toggle, so `osc_out` holds for one extra tick period (2·`PHASES` clocks between toggles instead of `PHASES`).
- R5: A request is held pending until its next eligible edge: a carry waits for a mid-phase cycle and a borrow waits for a tick cycle. A pulse that arrives in an eligible cycle is applied in that same cycle.
- R6: When a carry and a borrow are pending together, both are discarded and neither is applied. This covers two pulses in the same cycle and one pulse arriving while the other kind is still waiting. Tick toggles continue as normal.
- R7: Repeated pulses of one kind that arrive before the first is consumed merge into a single request.
- R8: Over a window in which every request is consumed and no two requests meet, the number of output toggles equals the nominal count plus the number of carries minus the number of borrows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock; `PHASES` cycles form one oscillator tick |
| rst | input | 1 | Synchronous active-high reset |
| carry_pulse | input | 1 | Speed-up request from the loop filter, one clock wide |
| borrow_pulse | input | 1 | Slow-down request from the loop filter, one clock wide |
| osc_out | output | 1 | Oscillator square wave towards the divide-by-N stage |

## Verification
Each run starts from reset and records, for each of 20 clocks, whether `osc_out` changed. The resulting toggle pattern is compared with an expected pattern.

- The quiet pattern shows the tick alignment.
- A single carry and a single borrow, each at a mid-phase cycle and at a tick cycle, separate immediate application from pending application. They also show the inserted toggle and the suppressed toggle.
- Same-cycle and staggered carry/borrow pairs separate cancellation from sequential application.
- A two-clock carry separates merging from double insertion.
- A request taken just before a reset shows whether reset really clears the pending state.

// File: rtl/incdec_osc_pkg.sv
package incdec_osc_pkg;

    // What the request stage does with the oscillator in the current cycle
    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_INSERT = 2'd1,
        ACT_DELETE = 2'd2,
        ACT_CANCEL = 2'd3
    } osc_act_e;

    // Pending speed-up / slow-down requests
    typedef struct packed {
        logic carry;
        logic borrow;
    } req_t;

    // Opposite requests annihilate; otherwise each waits for its own slot
    function automatic osc_act_e pick_action(input req_t eff, input logic mid, input logic tick);
        if (eff.carry && eff.borrow) return ACT_CANCEL;
        if (eff.carry && mid)        return ACT_INSERT;
        if (eff.borrow && tick)      return ACT_DELETE;
        return ACT_NONE;
    endfunction

    // Request state left after an action has been taken
    function automatic req_t next_pending(input req_t eff, input osc_act_e act);
        req_t r;
        r = eff;
        case (act)
            ACT_CANCEL: r = '0;
            ACT_INSERT: r.carry = 1'b0;
            ACT_DELETE: r.borrow = 1'b0;
            default:    r = eff;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/incdec_phase.sv
module incdec_phase #(
    parameter int PHASES = 2
) (
    input  logic clk,
    input  logic rst,
    output logic tick,
    output logic mid
);
    localparam int PW      = (PHASES > 2) ? $clog2(PHASES) : 1;
    localparam int LAST    = PHASES - 1;
    localparam int MIDSLOT = PHASES / 2 - 1;

    generate
        if (PHASES == 2) begin : g_two
            logic half;
            always_ff @(posedge clk) begin
                if (rst) half <= 1'b0;
                else     half <= ~half;
            end
            assign tick = half;
            assign mid  = ~half;
        end else begin : g_cnt
            logic [PW-1:0] ph;
            always_ff @(posedge clk) begin
                if (rst)                       ph <= '0;
                else if (ph == PW'(LAST))      ph <= '0;
                else                           ph <= ph + 1'b1;
            end
            assign tick = (ph == PW'(LAST));
            assign mid  = (ph == PW'(MIDSLOT));
        end
    endgenerate
endmodule

// File: rtl/incdec_req.sv
module incdec_req
    import incdec_osc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     carry_pulse,
    input  logic     borrow_pulse,
    input  logic     tick,
    input  logic     mid,
    output osc_act_e act,
    output req_t     pend
);
    req_t eff;

    always_comb begin
        eff.carry  = pend.carry  | carry_pulse;
        eff.borrow = pend.borrow | borrow_pulse;
        act        = pick_action(eff, mid, tick);
    end

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= next_pending(eff, act);
    end
endmodule

// File: rtl/incdec_toggle.sv
module incdec_toggle
    import incdec_osc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  osc_act_e act,
    output logic     q
);
    logic flip;

    always_comb begin
        flip = (tick && (act != ACT_DELETE)) || (act == ACT_INSERT);
    end

    always_ff @(posedge clk) begin
        if (rst)       q <= 1'b0;
        else if (flip) q <= ~q;
    end
endmodule

// File: rtl/incdec_osc.sv
module incdec_osc
    import incdec_osc_pkg::*;
#(
    parameter int PHASES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic carry_pulse,
    input  logic borrow_pulse,
    output logic osc_out
);
    logic     tick;
    logic     mid;
    osc_act_e act;
    req_t     pend;

    incdec_phase #(.PHASES(PHASES)) u_phase (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .mid  (mid)
    );

    incdec_req u_req (
        .clk          (clk),
        .rst          (rst),
        .carry_pulse  (carry_pulse),
        .borrow_pulse (borrow_pulse),
        .tick         (tick),
        .mid          (mid),
        .act          (act),
        .pend         (pend)
    );

    incdec_toggle u_tog (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .act  (act),
        .q    (osc_out)
    );
endmodule

// File: rtl/incdec_osc_chk.sv
module incdec_osc_chk
    import incdec_osc_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     carry_pulse,
    input logic     borrow_pulse,
    input logic     osc_out,
    input logic     tick,
    input logic     mid,
    input osc_act_e act,
    input req_t     pend
);
    // R1: reset forces the output low
    a_r1_reset_low: assert property (@(posedge clk) rst |=> !osc_out);

    // R1: reset discards pending requests
    a_r1_reset_clears: assert property (@(posedge clk) rst |=> (pend == '0));

    // R2: tick and mid slots never coincide
    a_r2_slots_exclusive: assert property (@(posedge clk) disable iff (rst) $onehot0({tick, mid}));

    // R2: an undisturbed tick flips the output
    a_r2_tick_flips: assert property (@(posedge clk) disable iff (rst)
        (tick && act == ACT_NONE) |=> (osc_out != $past(osc_out)));

    // R2: outside a tick, only an insertion can move the output
    a_r2_quiet_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && act != ACT_INSERT) |=> $stable(osc_out));

    // R3: an insertion flips the output
    a_r3_insert_flips: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_INSERT) |=> (osc_out != $past(osc_out)));

    // R4: a deletion holds the output
    a_r4_delete_holds: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_DELETE) |=> $stable(osc_out));

    // R6: simultaneous opposite pulses leave nothing pending
    a_r6_cancel_clears: assert property (@(posedge clk) disable iff (rst)
        (carry_pulse && borrow_pulse) |=> (pend == '0));
endmodule

bind incdec_osc incdec_osc_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .carry_pulse  (carry_pulse),
    .borrow_pulse (borrow_pulse),
    .osc_out      (osc_out),
    .tick         (tick),
    .mid          (mid),
    .act          (act),
    .pend         (pend)
);

// File: tb/test_incdec_osc.sv
module test_incdec_osc;
    localparam int WIN  = 20;
    localparam int NVEC = 10;
    localparam logic [WIN-1:0] NOM = 20'hAAAAA;  // toggles at cycles 1,3,5,... after release

    // {carry mask, borrow mask, expected toggle mask}
    localparam logic [3*WIN-1:0] VEC [NVEC] = '{
        {20'h00000, 20'h00000, 20'hAAAAA},  // R2 quiet
        {20'h00004, 20'h00000, 20'hAAAAE},  // R3 carry at mid slot
        {20'h00000, 20'h00004, 20'hAAAA2},  // R4 borrow waits for tick (R5)
        {20'h00020, 20'h00020, 20'hAAAAA},  // R6 same-cycle cancel
        {20'h00008, 20'h00010, 20'hAAAAA},  // R6 pending carry meets borrow
        {20'h00018, 20'h00000, 20'hAAABA},  // R7 two-clock carry merges
        {20'h00202, 20'h00000, 20'hAAEAE},  // R5 carries at tick wait for mid
        {20'h00000, 20'h00202, 20'hAA8A8},  // R4 borrows at tick apply at once
        {20'h00004, 20'h00400, 20'hAA2AE},  // R8 carry then borrow
        {20'h00001, 20'h00000, 20'hAAAAB}   // R3 carry in first cycle
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic carry_pulse = 1'b0;
    logic borrow_pulse = 1'b0;
    logic osc_out;
    int   errors = 0;
    int   checks = 0;

    always #5 clk = ~clk;

    incdec_osc i_incdec_osc (
        .clk          (clk),
        .rst          (rst),
        .carry_pulse  (carry_pulse),
        .borrow_pulse (borrow_pulse),
        .osc_out      (osc_out)
    );

    function automatic string vec_tag(input int v);
        case (v)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R6";
            4: return "R6";
            5: return "R7";
            6: return "R5";
            7: return "R4";
            8: return "R8";
            default: return "R3";
        endcase
    endfunction

    task automatic check(input string tag, input logic [WIN-1:0] got, input logic [WIN-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %05h expected %05h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Ends at a falling edge with reset just released
    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; carry_pulse = 1'b0; borrow_pulse = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Called at a falling edge; records which cycles changed the output
    task automatic run_window(input logic [WIN-1:0] cm, input logic [WIN-1:0] bm,
                              output logic [WIN-1:0] tmask);
        logic prev;
        tmask = '0;
        for (int i = 0; i < WIN; i++) begin
            carry_pulse = cm[i];
            borrow_pulse = bm[i];
            prev = osc_out;
            @(posedge clk);
            #1;
            tmask[i] = (osc_out !== prev);
            @(negedge clk);
        end
        carry_pulse = 1'b0;
        borrow_pulse = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [WIN-1:0] got;
        do_reset();
        check("R1 low after reset", {19'd0, osc_out}, '0);

        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            run_window(VEC[v][3*WIN-1:2*WIN], VEC[v][2*WIN-1:WIN], got);
            check(vec_tag(v), got, VEC[v][WIN-1:0]);
        end

        // R1: reset from a high output drives it low
        do_reset();
        run_window(20'h00004, 20'h00000, got);   // 11 toggles leaves output high
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1 reset from high", {19'd0, osc_out}, '0);
        @(negedge clk);

        // R1: a carry left pending at reset must not appear afterwards
        do_reset();
        carry_pulse = 1'b0;
        @(negedge clk);
        carry_pulse = 1'b1;                      // tick cycle: request stays pending
        @(negedge clk);
        carry_pulse = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        run_window('0, '0, got);
        check("R1 pending cleared", got, NOM);

        finish_run();
    end
endmodule